// File: doc/BRIEF.md
# Static Dataflow Instruction Cell

This block is a single instruction cell of a static dataflow machine. It holds the instruction's opcode and its result destination addresses on configuration pins, and it keeps two operand slots. Each slot takes data tokens, boolean control tokens and gate tokens. The cell also counts the acknowledges that come back from the cells it feeds. When the firing rule is met, it offers one operation packet. The packet carries the opcode, both operand values and the destination field.

The static rule allows at most one token per arc. A slot therefore refuses a second token until the cell has fired. The cell will not fire again until every consumer of its previous result has acknowledged it. A slot can be a constant, which is always present and never consumed, or a variable, which the firing clears. A slot can also be gated, so that it needs a true or a false gate token before it counts as ready. A gate of the wrong polarity throws the waiting token away. Unary instructions look only at the first slot.

The data and control inputs and the packet output are valid/ready streams. An input is taken in a cycle where valid and ready are both high. Ready for a slot depends only on that slot's state and never on the input's own valid. The packet output raises valid when the cell can fire. It then holds valid and the whole payload steady until ready is seen, and the cell fires in that cycle. Configuration pins are treated as static: change them only while reset is held.

Top module: `df_static_cell`

## Requirements
- R1: After reset, op_valid is low, dat_ready and ctl_ready are high for every slot, and no acknowledge is owed.
- R2: With both slots variable and ungated, op_valid rises only once both slots hold a token. op_a carries slot 0 (dat_slot=0) and op_b carries slot 1 (dat_slot=1). op_opcode and op_dest equal cfg_opcode and cfg_dest.
- R3: A constant slot (cfg_const bit i set for slot i) always counts as present and supplies cfg_const_a or cfg_const_b. Firing does not consume it. A data token sent to it is accepted and has no effect on the packet.
- R4: With cfg_unary=1, slot 1 is ignored. Readiness needs only slot 0, tokens for slot 1 are accepted and dropped, and op_b reads zero.
- R5: A variable slot holding a token shows dat_ready low for that slot until the cell fires. After the firing it shows dat_ready high again.
- R6: After firing, the cell may not fire again until cfg_ack_n acknowledge pulses (ack_in high for one cycle each) have been counted. Acknowledges that arrive while none are owed, or that arrive in the cycle the cell fires, are not counted. With cfg_ack_n=0 the cell may fire back to back.
- R7: A gated slot counts as present only when its gate flag matches its requirement. cfg_gate_* encodes the requirement as 0 none, 1 needs true, 2 needs false. A gate token is ctl_kind=0 with the polarity on ctl_bool. Firing clears gate flags, so the slot accepts a new gate token afterwards.
- R8: A gate of the wrong polarity on a slot holding a token discards both the token and the gate flag one cycle after they coexist. The slot then accepts new tokens, and the cell does not fire.
- R9: A control token of data type (ctl_kind=1) stores ctl_bool as the slot's value, in bit 0 with all other bits zero.
- R10: While op_valid is high and op_ready is low, op_valid stays high and op_a and op_b stay unchanged.
- R11: When a data token and a data-type control token target the same slot in the same cycle, the data token wins and ctl_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_opcode | input | OPC_W | Instruction opcode |
| cfg_dest | input | NDEST*ADDR_W | Packed result destination addresses |
| cfg_unary | input | 1 | Instruction uses slot 0 only |
| cfg_const | input | 2 | Per-slot constant mode |
| cfg_const_a | input | DATA_W | Constant value of slot 0 |
| cfg_const_b | input | DATA_W | Constant value of slot 1 |
| cfg_gate_a | input | 2 | Gate requirement of slot 0 |
| cfg_gate_b | input | 2 | Gate requirement of slot 1 |
| cfg_ack_n | input | ACK_W | Acknowledges expected per firing |
| dat_valid | input | 1 | Data token valid |
| dat_ready | output | 1 | Addressed slot can take a data token |
| dat_slot | input | 1 | Target slot of the data token |
| dat_value | input | DATA_W | Data token value |
| ctl_valid | input | 1 | Control token valid |
| ctl_ready | output | 1 | Addressed slot can take the control token |
| ctl_kind | input | 1 | 0 gate token, 1 boolean data token |
| ctl_slot | input | 1 | Target slot of the control token |
| ctl_bool | input | 1 | Boolean carried by the control token |
| ack_in | input | 1 | One acknowledge per high cycle |
| op_valid | output | 1 | Operation packet offered |
| op_ready | input | 1 | Packet consumer ready; firing occurs on valid and ready |
| op_opcode | output | OPC_W | Packet opcode |
| op_a | output | DATA_W | Packet first operand |
| op_b | output | DATA_W | Packet second operand |
| op_dest | output | NDEST*ADDR_W | Packet destinations |

## Verification
Two pairs of events can land in the same cycle. The first pair is an acknowledge pulse and the firing handshake. The bench raises ack_in together with op_ready. It then shows that one further acknowledge is not enough to re-enable the cell and that the full count is. The second pair is a data token and a boolean control token aimed at the same slot. The bench presents both at once, checks that ctl_ready is low, and checks that the fired packet carries the data value.

// File: rtl/df_cell_pkg.sv
package df_cell_pkg;

  // Gate flag held by an operand slot.
  typedef enum logic [1:0] {
    GF_OFF   = 2'd0,
    GF_TRUE  = 2'd1,
    GF_FALSE = 2'd2
  } gflag_e;

  // Gate requirement encoding on the configuration pins.
  localparam logic [1:0] GREQ_NONE  = 2'd0;
  localparam logic [1:0] GREQ_TRUE  = 2'd1;
  localparam logic [1:0] GREQ_FALSE = 2'd2;

  localparam int NSLOT = 2;

endpackage

// File: rtl/df_operand_slot.sv
module df_operand_slot
  import df_cell_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_const,
  input  logic              inactive,
  input  logic [DATA_W-1:0] const_val,
  input  logic [1:0]        gate_req,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_val,
  input  logic              gate_en,
  input  logic              gate_bool,
  input  logic              fire_clr,
  output logic              present,
  output logic [DATA_W-1:0] value,
  output logic              wr_rdy,
  output logic              gate_rdy
);

  logic              vflag;
  logic [DATA_W-1:0] vreg;
  gflag_e            gflag;

  logic holds_val, gated, gmatch, gmiss, drop, take, gtake;

  always_comb begin
    holds_val = is_const || vflag;
    gated     = (gate_req != GREQ_NONE);
    gmatch    = ((gate_req == GREQ_TRUE)  && (gflag == GF_TRUE)) ||
                ((gate_req == GREQ_FALSE) && (gflag == GF_FALSE));
    gmiss     = gated && (gflag != GF_OFF) && !gmatch;
    drop      = !inactive && gmiss && holds_val;
    present   = inactive || (holds_val && (!gated || gmatch));
    wr_rdy    = inactive || is_const || !vflag;
    gate_rdy  = inactive || !gated || (gflag == GF_OFF);
    take      = wr_en && wr_rdy && !inactive && !is_const && !fire_clr && !drop;
    gtake     = gate_en && gate_rdy && gated && !inactive && !fire_clr && !drop;
    value     = is_const ? const_val : vreg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vflag <= 1'b0;
      vreg  <= '0;
      gflag <= GF_OFF;
    end else if ((fire_clr && !inactive) || drop) begin
      vflag <= 1'b0;
      gflag <= GF_OFF;
    end else begin
      if (take) begin
        vflag <= 1'b1;
        vreg  <= wr_val;
      end
      if (gtake) gflag <= gate_bool ? GF_TRUE : GF_FALSE;
    end
  end

  // R5: a taken token occupies the slot in the following cycle
  a_r5_take_occupies: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (vflag && !wr_rdy));

  // R8: a mismatched gate empties the slot on the next edge
  a_r8_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ((gflag == GF_OFF) && (wr_rdy || is_const)));

endmodule

// File: rtl/df_ack_tally.sv
module df_ack_tally #(
  parameter int ACK_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_in,
  input  logic             fire,
  input  logic [ACK_W-1:0] need_n,
  output logic             arcs_clear
);

  logic             owes;
  logic [ACK_W-1:0] got_m;

  assign arcs_clear = !owes || (got_m == need_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owes  <= 1'b0;
      got_m <= '0;
    end else if (fire) begin
      owes  <= 1'b1;
      got_m <= '0;
    end else if (ack_in && owes && (got_m != need_n)) begin
      got_m <= got_m + 1'b1;
    end
  end

  // R6: the count never passes the expected number
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    owes |-> (got_m <= need_n));

  // R6: no firing while acknowledges are still owed
  a_r6_no_early_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (owes && (got_m != need_n)) |-> !fire);

endmodule

// File: rtl/df_static_cell.sv
module df_static_cell
  import df_cell_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int NDEST  = 2,
  parameter int OPC_W  = 6,
  localparam int ACK_W = $clog2(NDEST + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [OPC_W-1:0]        cfg_opcode,
  input  logic [NDEST*ADDR_W-1:0] cfg_dest,
  input  logic                    cfg_unary,
  input  logic [1:0]              cfg_const,
  input  logic [DATA_W-1:0]       cfg_const_a,
  input  logic [DATA_W-1:0]       cfg_const_b,
  input  logic [1:0]              cfg_gate_a,
  input  logic [1:0]              cfg_gate_b,
  input  logic [ACK_W-1:0]        cfg_ack_n,
  input  logic                    dat_valid,
  output logic                    dat_ready,
  input  logic                    dat_slot,
  input  logic [DATA_W-1:0]       dat_value,
  input  logic                    ctl_valid,
  output logic                    ctl_ready,
  input  logic                    ctl_kind,
  input  logic                    ctl_slot,
  input  logic                    ctl_bool,
  input  logic                    ack_in,
  output logic                    op_valid,
  input  logic                    op_ready,
  output logic [OPC_W-1:0]        op_opcode,
  output logic [DATA_W-1:0]       op_a,
  output logic [DATA_W-1:0]       op_b,
  output logic [NDEST*ADDR_W-1:0] op_dest
);

  logic [DATA_W-1:0] cval [NSLOT];
  logic [1:0]        greq [NSLOT];
  logic [DATA_W-1:0] sval [NSLOT];
  logic [NSLOT-1:0]  inact, present, wr_rdy, gate_rdy;
  logic              fire, arcs_clear, same_slot;

  assign cval[0]  = cfg_const_a;
  assign cval[1]  = cfg_const_b;
  assign greq[0]  = cfg_gate_a;
  assign greq[1]  = cfg_gate_b;
  assign inact[0] = 1'b0;
  assign inact[1] = cfg_unary;

  assign same_slot = dat_valid && (dat_slot == ctl_slot);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic              dat_hit, cdat_hit, gate_hit;
    logic [DATA_W-1:0] wr_val;

    assign dat_hit  = dat_valid && (dat_slot == 1'(i));
    assign cdat_hit = ctl_valid && ctl_kind && (ctl_slot == 1'(i)) && !dat_hit;
    assign gate_hit = ctl_valid && !ctl_kind && (ctl_slot == 1'(i));
    assign wr_val   = dat_hit ? dat_value : DATA_W'(ctl_bool);

    df_operand_slot #(.DATA_W(DATA_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .is_const (cfg_const[i]),
      .inactive (inact[i]),
      .const_val(cval[i]),
      .gate_req (greq[i]),
      .wr_en    (dat_hit || cdat_hit),
      .wr_val   (wr_val),
      .gate_en  (gate_hit),
      .gate_bool(ctl_bool),
      .fire_clr (fire),
      .present  (present[i]),
      .value    (sval[i]),
      .wr_rdy   (wr_rdy[i]),
      .gate_rdy (gate_rdy[i])
    );
  end

  df_ack_tally #(.ACK_W(ACK_W)) u_ack (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_in    (ack_in),
    .fire      (fire),
    .need_n    (cfg_ack_n),
    .arcs_clear(arcs_clear)
  );

  always_comb begin
    dat_ready = wr_rdy[dat_slot];
    ctl_ready = ctl_kind ? (wr_rdy[ctl_slot] && !same_slot) : gate_rdy[ctl_slot];
    op_valid  = (&present) && arcs_clear;
    fire      = op_valid && op_ready;
    op_opcode = cfg_opcode;
    op_dest   = cfg_dest;
    op_a      = sval[0];
    op_b      = cfg_unary ? '0 : sval[1];
  end

  // R10: an offered packet is held unchanged until taken
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |=> (op_valid && $stable(op_a) && $stable(op_b)));

  // R11: a data-type control token yields to a data token on the same slot
  a_r11_data_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && ctl_kind && same_slot) |-> !ctl_ready);

endmodule

// File: tb/tb_df_static_cell.sv
module tb_df_static_cell;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int ND = 2;
  localparam int OW = 6;
  localparam int KW = $clog2(ND + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [OW-1:0] cfg_opcode = 6'h2B;
  logic [ND*AW-1:0] cfg_dest = 16'hA53C;
  logic cfg_unary = 1'b0;
  logic [1:0] cfg_const = 2'b00;
  logic [DW-1:0] cfg_const_a = 16'h1111, cfg_const_b = 16'h0055;
  logic [1:0] cfg_gate_a = 2'd0, cfg_gate_b = 2'd0;
  logic [KW-1:0] cfg_ack_n = '0;
  logic dat_valid = 0, dat_slot = 0, ctl_valid = 0, ctl_kind = 0, ctl_slot = 0, ctl_bool = 0;
  logic ack_in = 0, op_ready = 0;
  logic [DW-1:0] dat_value = '0;
  logic dat_ready, ctl_ready, op_valid;
  logic [OW-1:0] op_opcode;
  logic [DW-1:0] op_a, op_b;
  logic [ND*AW-1:0] op_dest;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  df_static_cell #(.DATA_W(DW), .ADDR_W(AW), .NDEST(ND), .OPC_W(OW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_opcode(cfg_opcode), .cfg_dest(cfg_dest),
    .cfg_unary(cfg_unary), .cfg_const(cfg_const), .cfg_const_a(cfg_const_a),
    .cfg_const_b(cfg_const_b), .cfg_gate_a(cfg_gate_a), .cfg_gate_b(cfg_gate_b),
    .cfg_ack_n(cfg_ack_n), .dat_valid(dat_valid), .dat_ready(dat_ready),
    .dat_slot(dat_slot), .dat_value(dat_value), .ctl_valid(ctl_valid),
    .ctl_ready(ctl_ready), .ctl_kind(ctl_kind), .ctl_slot(ctl_slot),
    .ctl_bool(ctl_bool), .ack_in(ack_in), .op_valid(op_valid), .op_ready(op_ready),
    .op_opcode(op_opcode), .op_a(op_a), .op_b(op_b), .op_dest(op_dest)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic restart(input logic un, input logic [1:0] cm, input logic [1:0] ga,
                         input logic [1:0] gb, input logic [KW-1:0] n);
    @(negedge clk);
    rst_n = 0;
    cfg_unary = un; cfg_const = cm; cfg_gate_a = ga; cfg_gate_b = gb; cfg_ack_n = n;
    tick();
    rst_n = 1;
    tick();
  endtask

  task automatic send_dat(input logic s, input logic [DW-1:0] v);
    dat_valid = 1; dat_slot = s; dat_value = v;
    tick();
    dat_valid = 0;
  endtask

  task automatic send_ctl(input logic k, input logic s, input logic b);
    ctl_valid = 1; ctl_kind = k; ctl_slot = s; ctl_bool = b;
    tick();
    ctl_valid = 0;
  endtask

  task automatic pulse_ack();
    ack_in = 1;
    tick();
    ack_in = 0;
  endtask

  task automatic take_pkt();
    op_ready = 1;
    tick();
    op_ready = 0;
  endtask

  function automatic logic [DW-1:0] va(input int i);
    return DW'(i * 37 + 5);
  endfunction

  function automatic logic [DW-1:0] vb(input int i);
    return DW'(16'hF0F0 ^ (i * 911));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1..R11 actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    restart(0, 2'b00, 2'd0, 2'd0, '0);
    chk("R1 op_valid", op_valid, 0);
    dat_slot = 0; #1 chk("R1 dat_ready slot0", dat_ready, 1);
    dat_slot = 1; #1 chk("R1 dat_ready slot1", dat_ready, 1);
    ctl_kind = 0; ctl_slot = 0; #1 chk("R1 ctl_ready", ctl_ready, 1);

    // R2 R5 R10 R6: binary variable sweep with no acknowledges expected
    for (int i = 0; i < 8; i++) begin
      send_dat(0, va(i));
      chk("R2 not ready with one operand", op_valid, 0);
      dat_slot = 0; #1 chk("R5 slot0 full", dat_ready, 0);
      send_dat(1, vb(i));
      chk("R2 ready with both", op_valid, 1);
      chk("R2 op_a", op_a, va(i));
      chk("R2 op_b", op_b, vb(i));
      chk("R2 opcode", op_opcode, 6'h2B);
      chk("R2 dest", op_dest, 16'hA53C);
      tick(); tick();
      chk("R10 held valid", op_valid, 1);
      chk("R10 held a", op_a, va(i));
      chk("R10 held b", op_b, vb(i));
      take_pkt();
      chk("R2 consumed", op_valid, 0);
      dat_slot = 0; #1 chk("R5 slot0 free after fire", dat_ready, 1);
    end
    send_dat(0, 16'h0101); send_dat(1, 16'h0202);
    chk("R6 n=0 refire", op_valid, 1);

    // R3 constant slot 1
    restart(0, 2'b10, 2'd0, 2'd0, '0);
    dat_slot = 1; #1 chk("R3 const slot accepts", dat_ready, 1);
    send_dat(1, 16'h0999);
    chk("R3 const alone not ready", op_valid, 0);
    for (int i = 0; i < 4; i++) begin
      send_dat(0, va(i + 20));
      chk("R3 fires with constant", op_valid, 1);
      chk("R3 op_b constant", op_b, 16'h0055);
      chk("R3 op_a", op_a, va(i + 20));
      take_pkt();
    end
    restart(0, 2'b11, 2'd0, 2'd0, '0);
    chk("R3 both constant ready", op_valid, 1);
    chk("R3 both const a", op_a, 16'h1111);

    // R4 unary
    restart(1, 2'b00, 2'd0, 2'd0, '0);
    dat_slot = 1; #1 chk("R4 slot1 accepts", dat_ready, 1);
    send_dat(1, 16'h7777);
    chk("R4 slot1 token does not fire", op_valid, 0);
    send_dat(0, 16'h3456);
    chk("R4 unary fires", op_valid, 1);
    chk("R4 op_b zero", op_b, 0);
    chk("R4 op_a", op_a, 16'h3456);

    // R6 acknowledge counting, with fire and ack in the same cycle
    restart(0, 2'b00, 2'd0, 2'd0, 2'd2);
    send_dat(0, 16'h0010); send_dat(1, 16'h0020);
    chk("R6 first fire needs no ack", op_valid, 1);
    take_pkt();
    send_dat(0, 16'h0011); send_dat(1, 16'h0021);
    chk("R6 blocked zero acks", op_valid, 0);
    pulse_ack();
    chk("R6 blocked one ack", op_valid, 0);
    pulse_ack();
    chk("R6 enabled two acks", op_valid, 1);
    op_ready = 1; ack_in = 1;
    tick();
    op_ready = 0; ack_in = 0;
    chk("R6 fired", op_valid, 0);
    send_dat(0, 16'h0012); send_dat(1, 16'h0022);
    pulse_ack();
    chk("R6 same-cycle ack not counted", op_valid, 0);
    pulse_ack();
    chk("R6 full count restores", op_valid, 1);
    chk("R6 payload", op_a, 16'h0012);

    // R7 R8 gating on slot 0 (needs true)
    restart(0, 2'b00, 2'd1, 2'd0, '0);
    send_dat(0, 16'h00AA); send_dat(1, 16'h00BB);
    chk("R7 waits for gate", op_valid, 0);
    send_ctl(0, 0, 1);
    chk("R7 true gate fires", op_valid, 1);
    chk("R7 op_a", op_a, 16'h00AA);
    take_pkt();
    ctl_kind = 0; ctl_slot = 0; #1 chk("R7 gate flag cleared", ctl_ready, 1);
    send_dat(0, 16'h00CC); send_dat(1, 16'h00DD);
    send_ctl(0, 0, 0);
    tick();
    dat_slot = 0; #1 chk("R8 token discarded", dat_ready, 1);
    ctl_kind = 0; ctl_slot = 0; #1 chk("R8 gate discarded", ctl_ready, 1);
    chk("R8 no fire", op_valid, 0);
    send_dat(0, 16'h00EE);
    send_ctl(0, 0, 1);
    chk("R8 refill fires", op_valid, 1);
    chk("R8 new value", op_a, 16'h00EE);
    chk("R8 slot1 kept", op_b, 16'h00DD);
    restart(0, 2'b00, 2'd0, 2'd2, '0);
    send_dat(0, 16'h0001); send_dat(1, 16'h0002);
    send_ctl(0, 1, 0);
    chk("R7 false gate fires", op_valid, 1);

    // R9 boolean data token, R11 collision
    restart(0, 2'b00, 2'd0, 2'd0, '0);
    send_dat(0, 16'h4242);
    send_ctl(1, 1, 1);
    chk("R9 ready via boolean", op_valid, 1);
    chk("R9 op_b", op_b, 16'h0001);
    take_pkt();
    send_dat(0, 16'h4343);
    dat_valid = 1; dat_slot = 1; dat_value = 16'hBEEF;
    ctl_valid = 1; ctl_kind = 1; ctl_slot = 1; ctl_bool = 1;
    #1 chk("R11 ctl_ready low", ctl_ready, 0);
    tick();
    dat_valid = 0; ctl_valid = 0;
    chk("R11 fires", op_valid, 1);
    chk("R11 data wins", op_b, 16'hBEEF);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule